// File: doc/BRIEF.md
# CAN Receive Record FIFO

This block is the receive store of a CAN controller. Frames that have already passed acceptance filtering arrive one whole frame per request. Each frame is packed into a circular byte buffer as a variable-length record. A record is an info byte, then two identifier bytes for a standard frame or four for an extended frame, then the payload bytes. Because records differ in size, the buffer holds as many frames as their real length allows rather than a fixed number of slots.

The host reads the oldest record through a byte window. Window offset k addresses the k-th byte of the oldest record. A release request drops that record. The size of the dropped record is worked out again from its stored info byte, so no length table is kept. The block tracks the byte fill and the number of stored messages. It raises a receive-ready status and a receive interrupt flag. A frame that would not fit is dropped whole and sets an overrun status and an overrun interrupt flag.

While the hold (configuration) input is high, the fill state is kept empty and incoming frames are refused. The buffer depth is a power of two and is 64 bytes by default.

Top module: `can_rx_fifo`

## Requirements
- R1: A standard frame is stored as a record whose byte 0 is the info byte. The info byte carries bit 7 = extended flag, bit 6 = remote flag, bits 5..4 = 0 and bits 3..0 = DLC. Byte 1 holds ID10..3, byte 2 holds ID2..0 in bits 7..5 with the other bits 0, and the payload follows from byte 3. The record length is 3 plus the payload count.
- R2: An extended frame is stored with ID28..21 in byte 1, ID20..13 in byte 2, ID12..5 in byte 3 and ID4..0 in bits 7..3 of byte 4, with bits 2..0 of byte 4 at 0. The payload follows from byte 5 and the record length is 5 plus the payload count.
- R3: A DLC above 8 is stored as 8 in the info byte and gives 8 payload bytes. A remote frame keeps its DLC in the info byte but stores no payload bytes.
- R4: A frame is accepted only if the byte fill plus its record length is at most the depth, so a frame that exactly fills the buffer is accepted. A frame that does not fit changes neither the fill nor the message count, and it sets the overrun status and the overrun interrupt flag.
- R5: A release of a non-empty FIFO works out the head record's length from its info byte. That length is 3, plus 2 if the extended flag is set, plus the clamped DLC if the remote flag is clear. The start position then advances by that length modulo the depth, and the fill drops by the length and the message count by one.
- R6: Each accepted frame sets receive-ready and the receive interrupt flag. A release that leaves zero messages clears both.
- R7: A release while the message count is zero changes nothing.
- R8: The read window at offset k returns the buffer byte at (start + k) modulo the depth, so a record that wraps past the end of the buffer reads back in order.
- R9: While the hold input is high, the fill, the message count, both positions and receive-ready are cleared, and incoming frames are not stored.
- R10: An interrupt acknowledge clears the overrun interrupt flag and rewrites the receive interrupt flag to whether messages remain. An overrun clear command clears the overrun status and the overrun interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| holdMode | input | 1 | Configuration hold: keeps the FIFO empty and refuses frames |
| wrValid | input | 1 | One-cycle request to store the frame on the wr* inputs |
| wrExt | input | 1 | Frame uses a 29-bit identifier |
| wrRtr | input | 1 | Frame is a remote request |
| wrDlc | input | 4 | Data length code |
| wrId | input | 29 | Identifier, right-aligned (standard frames use bits 10..0) |
| wrData | input | 64 | Payload, byte i in bits 8i+7..8i |
| releaseReq | input | 1 | One-cycle request to drop the oldest record |
| intAck | input | 1 | Interrupt acknowledge (read-to-clear of the interrupt flags) |
| clrOverrun | input | 1 | Clear overrun status and overrun interrupt flag |
| rdOffset | input | 4 | Byte offset into the oldest record |
| rdData | output | 8 | Byte at the read window offset |
| byteCount | output | clog2(DEPTH+1) | Bytes in use |
| msgCount | output | clog2(DEPTH+1) | Records stored |
| rxReady | output | 1 | Receive-buffer status: at least one record stored |
| overrun | output | 1 | Overrun status |
| rxInt | output | 1 | Receive interrupt flag |
| ovrInt | output | 1 | Overrun interrupt flag |

## Verification
A bad start position or a wrong release length shows up at the window at once. The very next read returns bytes from the middle of a record instead of its info byte, and the fill then drifts away from the sum of the stored record lengths. The bench compares the whole head record and every count after each single operation, so such an error is seen in the cycle after it happens. A wrong fit test shows up only at the exact-fill boundary, so that boundary is driven on purpose. The ready and interrupt flags are compared on every step, including the release that empties the FIFO.

// File: rtl/can_rx_fifo_pkg.sv
package can_rx_fifo_pkg;

  // Longest record: info + four identifier bytes + eight payload bytes
  localparam int unsigned MAX_REC = 13;

  // Strobes from the control path to the byte store
  typedef struct packed {
    logic       doStore;
    logic       doRelease;
    logic       doClear;
    logic [3:0] relLen;
  } fifoStrobes_t;

  // Record length from the fields held in an info byte
  function automatic logic [3:0] recordLength(input logic ext, input logic rtr,
                                              input logic [3:0] dlc);
    logic [3:0] payload;
    payload = rtr ? 4'd0 : ((dlc > 4'd8) ? 4'd8 : dlc);
    return (ext ? 4'd5 : 4'd3) + payload;
  endfunction

endpackage

// File: rtl/can_rx_rec_encoder.sv
module can_rx_rec_encoder
  import can_rx_fifo_pkg::*;
(
  input  logic                   ext,
  input  logic                   rtr,
  input  logic [3:0]             dlc,
  input  logic [28:0]            id,
  input  logic [63:0]            data,
  output logic [MAX_REC*8-1:0]   recBytes,
  output logic [3:0]             recLen
);

  logic [3:0] dlcClamped;
  logic [3:0] payload;

  always_comb begin
    dlcClamped = (dlc > 4'd8) ? 4'd8 : dlc;
    payload    = rtr ? 4'd0 : dlcClamped;
    recBytes   = '0;
    recBytes[7:0] = {ext, rtr, 2'b00, dlcClamped};
    if (ext) begin
      recBytes[15:8]  = id[28:21];
      recBytes[23:16] = id[20:13];
      recBytes[31:24] = id[12:5];
      recBytes[39:32] = {id[4:0], 3'b000};
      for (int i = 0; i < 8; i++) begin
        if (4'(i) < payload) recBytes[40 + 8*i +: 8] = data[8*i +: 8];
      end
    end else begin
      recBytes[15:8]  = id[10:3];
      recBytes[23:16] = {id[2:0], 5'b00000};
      for (int i = 0; i < 8; i++) begin
        if (4'(i) < payload) recBytes[24 + 8*i +: 8] = data[8*i +: 8];
      end
    end
  end

  assign recLen = recordLength(ext, rtr, dlc);

endmodule

// File: rtl/can_rx_fifo_datapath.sv
module can_rx_fifo_datapath
  import can_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  fifoStrobes_t          strb,
  input  logic [MAX_REC*8-1:0]  recBytes,
  input  logic [3:0]            recLen,
  input  logic [3:0]            rdOffset,
  output logic [7:0]            rdData,
  output logic [7:0]            headInfo
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] startPtr;

  // Whole record written in one cycle; positions wrap by truncation
  always_ff @(posedge clk) begin
    if (strb.doStore) begin
      for (int i = 0; i < MAX_REC; i++) begin
        if (4'(i) < recLen) mem[wrPtr + AW'(i)] <= recBytes[8*i +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      startPtr <= '0;
    end else if (strb.doClear) begin
      wrPtr    <= '0;
      startPtr <= '0;
    end else begin
      if (strb.doStore)   wrPtr    <= wrPtr + AW'(recLen);
      if (strb.doRelease) startPtr <= startPtr + AW'(strb.relLen);
    end
  end

  assign rdData   = mem[startPtr + AW'(rdOffset)];
  assign headInfo = mem[startPtr];

endmodule

// File: rtl/can_rx_fifo_ctrl.sv
module can_rx_fifo_ctrl
  import can_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         holdMode,
  input  logic                         wrValid,
  input  logic [3:0]                   recLen,
  input  logic                         releaseReq,
  input  logic                         intAck,
  input  logic                         clrOverrun,
  input  logic [7:0]                   headInfo,
  output fifoStrobes_t                 strb,
  output logic [$clog2(DEPTH+1)-1:0]   byteCount,
  output logic [$clog2(DEPTH+1)-1:0]   msgCount,
  output logic                         rxReady,
  output logic                         overrun,
  output logic                         rxInt,
  output logic                         ovrInt
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          fits;
  logic          storeOk;
  logic          dropEv;
  logic          relOk;
  logic [3:0]    relLen;
  logic [CW-1:0] byteNext;
  logic [CW-1:0] msgNext;

  always_comb begin
    fits    = ((CW+1)'(byteCount) + (CW+1)'(recLen)) <= (CW+1)'(DEPTH);
    storeOk = wrValid & ~holdMode & fits;
    dropEv  = wrValid & ~holdMode & ~fits;
    relOk   = releaseReq & ~holdMode & (msgCount != '0);
    relLen  = recordLength(headInfo[7], headInfo[6], headInfo[3:0]);

    byteNext = byteCount;
    msgNext  = msgCount;
    if (storeOk) begin
      byteNext = byteNext + CW'(recLen);
      msgNext  = msgNext + CW'(1);
    end
    if (relOk) begin
      byteNext = byteNext - CW'(relLen);
      msgNext  = msgNext - CW'(1);
    end

    strb.doStore   = storeOk;
    strb.doRelease = relOk;
    strb.doClear   = holdMode;
    strb.relLen    = relLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCount <= '0;
      msgCount  <= '0;
      rxReady   <= 1'b0;
    end else if (holdMode) begin
      byteCount <= '0;
      msgCount  <= '0;
      rxReady   <= 1'b0;
    end else begin
      byteCount <= byteNext;
      msgCount  <= msgNext;
      rxReady   <= (msgNext != '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxInt   <= 1'b0;
      overrun <= 1'b0;
      ovrInt  <= 1'b0;
    end else begin
      if (storeOk)                       rxInt <= 1'b1;
      else if (relOk && msgNext == '0)   rxInt <= 1'b0;
      else if (intAck)                   rxInt <= (msgCount != '0);

      if (dropEv)          overrun <= 1'b1;
      else if (clrOverrun) overrun <= 1'b0;

      if (dropEv)                    ovrInt <= 1'b1;
      else if (clrOverrun || intAck) ovrInt <= 1'b0;
    end
  end

endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo
  import can_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         holdMode,
  input  logic                         wrValid,
  input  logic                         wrExt,
  input  logic                         wrRtr,
  input  logic [3:0]                   wrDlc,
  input  logic [28:0]                  wrId,
  input  logic [63:0]                  wrData,
  input  logic                         releaseReq,
  input  logic                         intAck,
  input  logic                         clrOverrun,
  input  logic [3:0]                   rdOffset,
  output logic [7:0]                   rdData,
  output logic [$clog2(DEPTH+1)-1:0]   byteCount,
  output logic [$clog2(DEPTH+1)-1:0]   msgCount,
  output logic                         rxReady,
  output logic                         overrun,
  output logic                         rxInt,
  output logic                         ovrInt
);

  logic [MAX_REC*8-1:0] recBytes;
  logic [3:0]           recLen;
  logic [7:0]           headInfo;
  fifoStrobes_t         strb;

  can_rx_rec_encoder enc_i (
    .ext      (wrExt),
    .rtr      (wrRtr),
    .dlc      (wrDlc),
    .id       (wrId),
    .data     (wrData),
    .recBytes (recBytes),
    .recLen   (recLen)
  );

  can_rx_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .holdMode   (holdMode),
    .wrValid    (wrValid),
    .recLen     (recLen),
    .releaseReq (releaseReq),
    .intAck     (intAck),
    .clrOverrun (clrOverrun),
    .headInfo   (headInfo),
    .strb       (strb),
    .byteCount  (byteCount),
    .msgCount   (msgCount),
    .rxReady    (rxReady),
    .overrun    (overrun),
    .rxInt      (rxInt),
    .ovrInt     (ovrInt)
  );

  can_rx_fifo_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .recBytes (recBytes),
    .recLen   (recLen),
    .rdOffset (rdOffset),
    .rdData   (rdData),
    .headInfo (headInfo)
  );

endmodule

// File: rtl/can_rx_fifo_chk.sv
module can_rx_fifo_chk #(
  parameter int unsigned DEPTH = 64
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         holdMode,
  input logic                         wrValid,
  input logic                         releaseReq,
  input logic [$clog2(DEPTH+1)-1:0]   byteCount,
  input logic [$clog2(DEPTH+1)-1:0]   msgCount,
  input logic                         rxReady,
  input logic                         rxInt,
  input logic                         ovrInt
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  AST_BYTES_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= CW'(DEPTH)); // R4

  AST_DROP_KEEPS_FILL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrInt) && !$past(releaseReq) |-> byteCount == $past(byteCount)); // R4

  AST_EMPTY_NO_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    msgCount == '0 |-> byteCount == '0); // R5

  AST_RELEASE_DECREMENTS: assert property (@(posedge clk) disable iff (!rstN)
    releaseReq && !holdMode && !wrValid && msgCount != '0
    |=> msgCount == $past(msgCount) - CW'(1)); // R5

  AST_READY_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    rxReady == (msgCount != '0)); // R6

  AST_STORE_RAISES_INT: assert property (@(posedge clk) disable iff (!rstN)
    msgCount > $past(msgCount) |-> rxInt); // R6

  AST_EMPTY_RELEASE_NOP: assert property (@(posedge clk) disable iff (!rstN)
    releaseReq && msgCount == '0 && !wrValid |=> msgCount == '0 && byteCount == '0); // R7

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    holdMode |=> byteCount == '0 && msgCount == '0 && !rxReady); // R9

endmodule

bind can_rx_fifo can_rx_fifo_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/can_rx_fifo_tb_top.sv
`timescale 1ns/1ps
module can_rx_fifo_tb_top;

  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          holdMode = 1'b1;
  logic          wrValid = 1'b0;
  logic          wrExt = 1'b0;
  logic          wrRtr = 1'b0;
  logic [3:0]    wrDlc = '0;
  logic [28:0]   wrId = '0;
  logic [63:0]   wrData = '0;
  logic          releaseReq = 1'b0;
  logic          intAck = 1'b0;
  logic          clrOverrun = 1'b0;
  logic [3:0]    rdOffset = '0;
  logic [7:0]    rdData;
  logic [CW-1:0] byteCount;
  logic [CW-1:0] msgCount;
  logic          rxReady, overrun, rxInt, ovrInt;

  always #10 clk = ~clk;

  can_rx_fifo #(.DEPTH(DEPTH)) dut_i (.*);

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  // Reference state built from the requirements
  byte unsigned mMem [DEPTH];
  int mStart = 0, mWr = 0, mCnt = 0, mMsg = 0;
  bit mReady = 0, mOvr = 0, mRxInt = 0, mOvrInt = 0, mHold = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int lenOf(input bit ext, input bit rtr, input int dlc);
    int p;
    p = rtr ? 0 : (dlc > 8 ? 8 : dlc);
    return (ext ? 5 : 3) + p;
  endfunction

  task automatic compareAll(input string tag);
    int lim;
    chk(byteCount == CW'(mCnt), {tag, " byteCount"}, byteCount, mCnt);
    chk(msgCount == CW'(mMsg), {tag, " msgCount"}, msgCount, mMsg);
    chk(rxReady == mReady, {tag, " rxReady"}, rxReady, mReady);
    chk(overrun == mOvr, {tag, " overrun"}, overrun, mOvr);
    chk(rxInt == mRxInt, {tag, " rxInt"}, rxInt, mRxInt);
    chk(ovrInt == mOvrInt, {tag, " ovrInt"}, ovrInt, mOvrInt);
    if (mMsg > 0) begin
      lim = lenOf(mMem[mStart][7], mMem[mStart][6], int'(mMem[mStart][3:0]));
      for (int k = 0; k < lim; k++) begin
        rdOffset = 4'(k);
        #1;
        chk(rdData == mMem[(mStart + k) % DEPTH], {tag, " window"}, rdData,
            mMem[(mStart + k) % DEPTH]);
      end
    end
  endtask

  task automatic readAt(input int k, output byte unsigned v);
    rdOffset = 4'(k);
    #1;
    v = rdData;
  endtask

  task automatic opStore(input bit ext, input bit rtr, input int dlc,
                         input logic [28:0] id, input logic [63:0] data,
                         input string tag);
    byte unsigned rec [13];
    int len, p;
    @(negedge clk);
    wrValid = 1; wrExt = ext; wrRtr = rtr; wrDlc = 4'(dlc); wrId = id; wrData = data;
    @(negedge clk);
    wrValid = 0;
    len = lenOf(ext, rtr, dlc);
    p = rtr ? 0 : (dlc > 8 ? 8 : dlc);
    rec[0] = {ext, rtr, 2'b00, 4'(dlc > 8 ? 8 : dlc)};
    if (ext) begin
      rec[1] = id[28:21]; rec[2] = id[20:13]; rec[3] = id[12:5]; rec[4] = {id[4:0], 3'b000};
      for (int i = 0; i < p; i++) rec[5 + i] = data[8*i +: 8];
    end else begin
      rec[1] = id[10:3]; rec[2] = {id[2:0], 5'b00000};
      for (int i = 0; i < p; i++) rec[3 + i] = data[8*i +: 8];
    end
    if (!mHold) begin
      if (mCnt + len > DEPTH) begin
        mOvr = 1; mOvrInt = 1;
      end else begin
        for (int i = 0; i < len; i++) mMem[(mWr + i) % DEPTH] = rec[i];
        mWr = (mWr + len) % DEPTH; mCnt += len; mMsg++; mReady = 1; mRxInt = 1;
      end
    end
    compareAll(tag);
  endtask

  task automatic opRelease(input string tag);
    int len;
    @(negedge clk);
    releaseReq = 1;
    @(negedge clk);
    releaseReq = 0;
    if (!mHold && mMsg > 0) begin
      len = lenOf(mMem[mStart][7], mMem[mStart][6], int'(mMem[mStart][3:0]));
      mStart = (mStart + len) % DEPTH; mCnt -= len; mMsg--;
      if (mMsg == 0) begin mReady = 0; mRxInt = 0; end
    end
    compareAll(tag);
  endtask

  task automatic opAck(input string tag);
    @(negedge clk);
    intAck = 1;
    @(negedge clk);
    intAck = 0;
    mOvrInt = 0; mRxInt = (mMsg != 0);
    compareAll(tag);
  endtask

  task automatic opClrOvr(input string tag);
    @(negedge clk);
    clrOverrun = 1;
    @(negedge clk);
    clrOverrun = 0;
    mOvr = 0; mOvrInt = 0;
    compareAll(tag);
  endtask

  task automatic setHold(input bit v, input string tag);
    @(negedge clk);
    holdMode = v;
    @(negedge clk);
    mHold = v;
    if (v) begin mCnt = 0; mMsg = 0; mStart = 0; mWr = 0; mReady = 0; end
    compareAll(tag);
  endtask

  task automatic drain(input string tag);
    while (mMsg > 0) opRelease(tag);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    compareAll("reset");
  endtask

  task automatic testHold();
    opStore(0, 0, 2, 29'h123, 64'h2211, "R9 store in hold");
    setHold(0, "R9 leave hold");
    opStore(0, 0, 1, 29'h111, 64'h77, "R9 store");
    setHold(1, "R9 hold clears");
    chk(rxReady == 1'b0, "R9 ready cleared", rxReady, 0);
    setHold(0, "R9 leave hold again");
  endtask

  task automatic testStandard();
    byte unsigned v;
    drain("R1 drain");
    opStore(0, 0, 2, 29'h5A3, 64'hCDAB, "R1 std");
    readAt(0, v); chk(v == 8'h02, "R1 info", v, 8'h02);
    readAt(1, v); chk(v == 8'hB4, "R1 id hi", v, 8'hB4);
    readAt(2, v); chk(v == 8'h60, "R1 id lo", v, 8'h60);
    readAt(3, v); chk(v == 8'hAB, "R1 data0", v, 8'hAB);
    readAt(4, v); chk(v == 8'hCD, "R1 data1", v, 8'hCD);
    chk(byteCount == 5, "R1 length", byteCount, 5);
    chk(rxReady && rxInt, "R6 set on store", {rxReady, rxInt}, 3);
  endtask

  task automatic testExtended();
    byte unsigned v;
    opStore(1, 0, 3, 29'h1ABCDEF3, 64'h332211, "R2 ext behind std");
    chk(byteCount == 13, "R2 fill", byteCount, 13);
    opRelease("R5 release std");
    readAt(0, v); chk(v == 8'h83, "R2 info", v, 8'h83);
    readAt(1, v); chk(v == 8'hD5, "R2 id28", v, 8'hD5);
    readAt(2, v); chk(v == 8'hE6, "R2 id20", v, 8'hE6);
    readAt(3, v); chk(v == 8'hF7, "R2 id12", v, 8'hF7);
    readAt(4, v); chk(v == 8'h98, "R2 id4", v, 8'h98);
    readAt(5, v); chk(v == 8'h11, "R2 data0", v, 8'h11);
    chk(byteCount == 8, "R5 fill after release", byteCount, 8);
  endtask

  task automatic testClampRemote();
    byte unsigned v;
    drain("R3 drain");
    opStore(0, 0, 12, 29'h7FF, 64'h8877665544332211, "R3 dlc12");
    readAt(0, v); chk(v == 8'h08, "R3 clamped info", v, 8'h08);
    chk(byteCount == 11, "R3 clamped length", byteCount, 11);
    opStore(0, 1, 5, 29'h0F0, 64'hFFFF, "R3 remote std");
    chk(byteCount == 14, "R3 remote length", byteCount, 14);
    opStore(1, 1, 8, 29'h0ABCDEF, 64'hFFFF, "R3 remote ext");
    chk(byteCount == 19, "R3 remote ext length", byteCount, 19);
    opRelease("R5 clamp release");
    opRelease("R5 remote release");
    chk(byteCount == 5, "R5 remote sized", byteCount, 5);
  endtask

  task automatic testEmpty();
    drain("R6 drain");
    chk(!rxReady && !rxInt, "R6 cleared at empty", {rxReady, rxInt}, 0);
    opRelease("R7 empty release");
    chk(msgCount == 0 && byteCount == 0, "R7 nothing changed", msgCount, 0);
  endtask

  task automatic testAck();
    opStore(0, 0, 0, 29'h001, 64'h0, "R10 store");
    opAck("R10 ack with msg");
    chk(rxInt == 1'b1, "R10 rx int kept", rxInt, 1);
    opRelease("R10 release");
    opAck("R10 ack empty");
    chk(rxInt == 1'b0, "R10 rx int clear", rxInt, 0);
  endtask

  task automatic testOverrun();
    for (int i = 0; i < 4; i++)
      opStore(1, 0, 8, 29'(32'h100 + i), 64'h0102030405060708 + 64'(i), "R8 fill");
    opStore(1, 0, 7, 29'h1FFFFFFF, 64'hA1A2A3A4A5A6A7, "R4 exact fit");
    chk(byteCount == 64, "R4 full", byteCount, 64);
    opStore(0, 1, 0, 29'h3, 64'h0, "R4 reject");
    chk(overrun && ovrInt, "R4 overrun flags", {overrun, ovrInt}, 3);
    chk(byteCount == 64 && msgCount == 5, "R4 unchanged", byteCount, 64);
    opAck("R10 ack clears ovrInt");
    opStore(0, 0, 8, 29'h4, 64'h0, "R4 reject again");
    opClrOvr("R10 clear overrun");
    chk(!overrun && !ovrInt, "R10 ovr cleared", {overrun, ovrInt}, 0);
    for (int i = 0; i < 3; i++) begin
      opRelease("R8 wrap release");
      opStore(0, 0, 8, 29'(i + 9), 64'hF0E0D0C0B0A09080 + 64'(i), "R8 wrap store");
    end
    drain("R8 wrap drain");
  endtask

  initial begin
    testReset();
    testHold();
    testStandard();
    testExtended();
    testClampRemote();
    testEmpty();
    testAck();
    testOverrun();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule